// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation structure kept in ordinary memory. The walk starts from a directory base address. The block reads one directory word and then one table word over a request/response memory port. Each word is checked against the access rights of the request. A walk ends with either a physical address or a fault report.

A client offers a request with a valid/ready handshake. The request carries the linear address, a user-mode flag, a write flag and a supervisor write-protect enable. The block accepts one walk at a time. When the walk finishes, it raises a one-cycle result strobe.

Each entry holds a 20-bit frame number in bits 31:12. Its low flag bits are: present in bit 0, writable in bit 1, user-accessible in bit 2. The linear address splits into three fields: the directory index in bits 31:22, the table index in bits 21:12, and the byte offset in bits 11:0.

Top module: `page_walker`

## Requirements
- R1: The first memory read of a walk is at address `pd_base + 4 * lin[31:22]`.
- R2: The second memory read is at address `(directory word AND 0xFFFFF000) + 4 * lin[21:12]`.
- R3: When a walk succeeds:
  - `res_fault` is 0 and `res_cause` is 0.
  - `res_phys_addr` equals `(table word AND 0xFFFFF000) + lin[11:0]`.
- R4: If an entry has bit 0 (present) clear, the walk faults with cause code 1. This cause wins over every other cause in the same entry.
- R5: If the request is user mode and the entry has bit 2 (user) clear, the walk faults with cause code 2. This cause wins over a write-denied cause in the same entry.
- R6: A write to an entry with bit 1 (writable) clear faults with cause code 3 in these cases:
  - always, in user mode;
  - in supervisor mode, only when `wp_en` is 1.
- R7: The rights checks cover the directory word first.
  - A directory fault reports level 0 and issues no table read.
  - A table fault reports level 1.
- R8: On a fault, `res_fault_addr` holds the linear address of the request.
- R9: Memory handshake:
  - `mem_req_valid` stays high with a stable address until `mem_req_ready` accepts it.
  - Exactly one read is issued per level that is walked.
  - `req_ready` is low while a walk is in progress.
- R10: After reset the block is idle: `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R11: `res_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_base | input | 32 | Physical address of the directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin_addr | input | 32 | Linear address to translate |
| req_user | input | 1 | 1 = user-mode access |
| req_write | input | 1 | 1 = write access |
| wp_en | input | 1 | Enforce read-only entries on supervisor writes |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Result strobe, one cycle |
| res_fault | output | 1 | Walk faulted |
| res_cause | output | 2 | 0 none, 1 absent, 2 user denied, 3 write denied |
| res_level | output | 1 | Fault level: 0 directory, 1 table |
| res_phys_addr | output | 32 | Translated physical address |
| res_fault_addr | output | 32 | Linear address that faulted |

## Verification
The bench targets the cause priorities, with entries that break several rules at once. A design with the wrong order would report user-denied or write-denied where absent is expected. It probes the supervisor write rule with the protect enable both on and off. A walker that ignores the enable would fault, or fail to fault, on read-only pages. It counts memory reads on directory-level faults to catch a stray table fetch. It also stalls the memory port to expose a request address that drifts or a read that is issued twice.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_USER   = 2'd2,
    FLT_WRITE  = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_PDE, S_CHECK_PDE, S_READ_PTE, S_CHECK_PTE, S_DONE
  } walk_e;

  localparam int FLAG_P = 0;
  localparam int FLAG_W = 1;
  localparam int FLAG_U = 2;
endpackage

// File: rtl/pgw_perm_check.sv
module pgw_perm_check
  import pgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] entry,
  input  logic          is_user,
  input  logic          is_write,
  input  logic          wp_en,
  output flt_e          cause
);
  // Priority: absent, then user denied, then write denied.
  always_comb begin
    if (!entry[FLAG_P])
      cause = FLT_ABSENT;
    else if (is_user && !entry[FLAG_U])
      cause = FLT_USER;
    else if (is_write && !entry[FLAG_W] && (is_user || wp_en))
      cause = FLT_WRITE;
    else
      cause = FLT_NONE;
  end
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int AW     = 32,
  parameter int OFS_W  = 12,
  parameter int TIDX_W = 10
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] lin,
  input  logic [AW-1:0] pde,
  input  logic [AW-1:0] pte,
  output logic [AW-1:0] pde_addr,
  output logic [AW-1:0] pte_addr,
  output logic [AW-1:0] phys
);
  localparam int DIDX_W = AW - OFS_W - TIDX_W;
  localparam int ENT_SH = 2;

  logic [DIDX_W-1:0] dir_idx;
  logic [TIDX_W-1:0] tbl_idx;
  logic [OFS_W-1:0]  ofs;

  assign dir_idx = lin[AW-1 -: DIDX_W];
  assign tbl_idx = lin[OFS_W +: TIDX_W];
  assign ofs     = lin[OFS_W-1:0];

  assign pde_addr = base + AW'({dir_idx, {ENT_SH{1'b0}}});
  assign pte_addr = {pde[AW-1:OFS_W], {OFS_W{1'b0}}} + AW'({tbl_idx, {ENT_SH{1'b0}}});
  assign phys     = {pte[AW-1:OFS_W], ofs};
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int OFS_W  = 12,
  parameter int TIDX_W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pd_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_lin_addr,
  input  logic          req_user,
  input  logic          req_write,
  input  logic          wp_en,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  output logic          res_fault,
  output logic [1:0]    res_cause,
  output logic          res_level,
  output logic [AW-1:0] res_phys_addr,
  output logic [AW-1:0] res_fault_addr
);
  walk_e         state;
  logic          issued;
  logic [AW-1:0] lin_q, pde_q, pte_q;
  logic          user_q, write_q, wp_q;
  logic [AW-1:0] pde_addr, pte_addr, phys;
  logic [AW-1:0] chk_entry;
  flt_e          cause;

  pgw_addr_gen #(.AW(AW), .OFS_W(OFS_W), .TIDX_W(TIDX_W)) u_addr (
    .base(pd_base), .lin(lin_q), .pde(pde_q), .pte(pte_q),
    .pde_addr(pde_addr), .pte_addr(pte_addr), .phys(phys)
  );

  assign chk_entry = (state == S_CHECK_PTE) ? pte_q : pde_q;

  pgw_perm_check #(.AW(AW)) u_perm (
    .entry(chk_entry), .is_user(user_q), .is_write(write_q),
    .wp_en(wp_q), .cause(cause)
  );

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = ((state == S_READ_PDE) || (state == S_READ_PTE)) && !issued;
  assign mem_req_addr  = (state == S_READ_PTE) ? pte_addr : pde_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      issued         <= 1'b0;
      lin_q          <= '0;
      pde_q          <= '0;
      pte_q          <= '0;
      user_q         <= 1'b0;
      write_q        <= 1'b0;
      wp_q           <= 1'b0;
      res_valid      <= 1'b0;
      res_fault      <= 1'b0;
      res_cause      <= 2'd0;
      res_level      <= 1'b0;
      res_phys_addr  <= '0;
      res_fault_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          lin_q   <= req_lin_addr;
          user_q  <= req_user;
          write_q <= req_write;
          wp_q    <= wp_en;
          state   <= S_READ_PDE;
        end
        S_READ_PDE, S_READ_PTE: begin
          if (mem_req_valid && mem_req_ready) issued <= 1'b1;
          if (issued && mem_rsp_valid) begin
            issued <= 1'b0;
            if (state == S_READ_PDE) begin
              pde_q <= mem_rsp_data;
              state <= S_CHECK_PDE;
            end else begin
              pte_q <= mem_rsp_data;
              state <= S_CHECK_PTE;
            end
          end
        end
        S_CHECK_PDE: begin
          if (cause != FLT_NONE) begin
            res_valid      <= 1'b1;
            res_fault      <= 1'b1;
            res_cause      <= cause;
            res_level      <= 1'b0;
            res_fault_addr <= lin_q;
            res_phys_addr  <= '0;
            state          <= S_DONE;
          end else begin
            state <= S_READ_PTE;
          end
        end
        S_CHECK_PTE: begin
          res_valid      <= 1'b1;
          res_fault      <= (cause != FLT_NONE);
          res_cause      <= cause;
          res_level      <= 1'b1;
          res_fault_addr <= lin_q;
          res_phys_addr  <= (cause == FLT_NONE) ? phys : '0;
          state          <= S_DONE;
        end
        S_DONE: begin
          res_valid <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: an unaccepted request keeps its address.
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7: a table read is issued only after a present directory word.
  p_pte_after_good_pde_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && (state == S_READ_PTE) |-> pde_q[FLAG_P]);

  // R11: the result strobe lasts a single cycle.
  p_result_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R4: a faulting result always carries a cause.
  p_fault_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_fault |-> res_cause != 2'd0);

  // R3: a clean result carries no cause.
  p_clean_no_cause_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault |-> res_cause == 2'd0);

  // R10: no memory traffic while idle.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pd_base;
  logic        req_valid, req_ready, req_user, req_write, wp_en;
  logic [31:0] req_lin_addr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        res_valid, res_fault, res_level;
  logic [1:0]  res_cause;
  logic [31:0] res_phys_addr, res_fault_addr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  page_walker u0 (
    .clk(clk), .rst(rst), .pd_base(pd_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin_addr(req_lin_addr),
    .req_user(req_user), .req_write(req_write), .wp_en(wp_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_cause(res_cause), .res_level(res_level),
    .res_phys_addr(res_phys_addr), .res_fault_addr(res_fault_addr)
  );

  // Memory model: 32 KB of words, one-cycle read latency.
  logic [31:0] mem [8192];
  logic        stall_mode = 1'b0;
  logic [1:0]  cyc = 2'd0;
  int          rd_cnt = 0;
  logic [31:0] addr_log [2];

  assign mem_req_ready = !stall_mode || (cyc == 2'd3);

  always @(posedge clk) begin
    cyc           <= cyc + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[14:2]];
      if (rd_cnt < 2) addr_log[rd_cnt] <= mem_req_addr;
      rd_cnt        <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Vector: la, user, write, wp, fault, cause, level, phys
  localparam logic [70:0] VECS [16] = '{
    {32'hF0000123, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h12345123},
    {32'hF0001ABC, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h91210ABC},
    {32'hF0002010, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 32'h0},
    {32'hF0002010, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h00055010},
    {32'hF0002010, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 32'h0},
    {32'hF0003000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0},
    {32'hF0003000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 32'h00066000},
    {32'hF0004000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0},
    {32'hF0005000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 32'h0},
    {32'h00400FFF, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0},
    {32'h00400FFF, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h000AAFFF},
    {32'h00800004, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0},
    {32'h00800004, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h000BB004},
    {32'h00C00000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0},
    {32'h00400000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 32'h0},
    {32'h00400000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h000AA000}
  };

  bit timed_out;

  task automatic walk(input logic [31:0] la, input logic u, input logic w, input logic wp);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt       = 0;
    req_valid    = 1'b1;
    req_lin_addr = la;
    req_user     = u;
    req_write    = w;
    wp_en        = wp;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    timed_out = 1'b0;
    while (!res_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!res_valid) begin
      timed_out = 1'b1;
      total++;
      bad++;
      $display("FAIL R11 actual=no result expected=result");
    end
  endtask

  task automatic check_walk(input logic [31:0] la, input logic efault,
                            input logic [1:0] ecause, input logic elvl,
                            input logic [31:0] epa);
    string tag;
    logic [31:0] pde;
    int ereads;
    if (timed_out) return;
    tag = !efault ? "R3" : (ecause == 2'd1) ? "R4" : (ecause == 2'd2) ? "R5" : "R6";
    chk(tag, {31'd0, res_fault}, {31'd0, efault});
    chk(tag, {30'd0, res_cause}, {30'd0, ecause});
    if (efault) begin
      chk("R7 level", {31'd0, res_level}, {31'd0, elvl});
      chk("R8", res_fault_addr, la);
    end else begin
      chk("R3 phys", res_phys_addr, epa);
    end
    ereads = (efault && !elvl) ? 1 : 2;
    chk("R7 reads", rd_cnt, ereads);
    chk("R1", addr_log[0], pd_base + {20'd0, la[31:22], 2'b00});
    if (ereads == 2) begin
      pde = mem[(pd_base[14:2] + {3'd0, la[31:22]})];
      chk("R2", addr_log[1], {pde[31:12], 12'h000} + {20'd0, la[21:12], 2'b00});
    end
    @(negedge clk);
    chk("R11 pulse", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
    mem[32'h3C0]    = 32'h0000_1007;
    mem[1]          = 32'h0000_2005;
    mem[2]          = 32'h0000_3003;
    mem[3]          = 32'h0000_0000;
    mem[1024 + 0]   = 32'h1234_5007;
    mem[1024 + 1]   = 32'h9121_0007;
    mem[1024 + 2]   = 32'h0005_5005;
    mem[1024 + 3]   = 32'h0006_6003;
    mem[1024 + 4]   = 32'h0007_7006;
    mem[1024 + 5]   = 32'h0008_8001;
    mem[2048 + 0]   = 32'h000A_A007;
    mem[3072 + 0]   = 32'h000B_B007;
    mem[4096 + 32'h3C0] = 32'h0000_1007;

    rst = 1'b1;
    pd_base = 32'h0;
    req_valid = 1'b0;
    req_lin_addr = '0;
    req_user = 1'b0;
    req_write = 1'b0;
    wp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 memv", {31'd0, mem_req_valid}, 32'd0);
    chk("R10 resv", {31'd0, res_valid}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      walk(VECS[i][70:39], VECS[i][38], VECS[i][37], VECS[i][36]);
      check_walk(VECS[i][70:39], VECS[i][35], VECS[i][34:33], VECS[i][32], VECS[i][31:0]);
    end

    // R1: a different directory base
    pd_base = 32'h0000_4000;
    walk(32'hF0001ABC, 1'b1, 1'b0, 1'b0);
    check_walk(32'hF0001ABC, 1'b0, 2'd0, 1'b0, 32'h91210ABC);
    pd_base = 32'h0;

    // R9: memory back-pressure, both levels
    stall_mode = 1'b1;
    walk(32'hF0000FFF, 1'b1, 1'b1, 1'b1);
    check_walk(32'hF0000FFF, 1'b0, 2'd0, 1'b0, 32'h12345FFF);
    walk(32'h00C00123, 1'b0, 1'b0, 1'b0);
    check_walk(32'h00C00123, 1'b1, 2'd1, 1'b0, 32'h0);
    stall_mode = 1'b0;

    // R10: reset in the middle of a walk returns to idle
    @(negedge clk);
    req_valid = 1'b1;
    req_lin_addr = 32'hF0000000;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 resv", {31'd0, res_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule